// File: doc/BRIEF.md
# Snooping Cache Write-Back Responder

This block is the processor-side bus front end of a small write-back cache that has to answer snoops from another bus master. While the other master owns the bus, it presents an address on the snoop port with a strobe and an invalidate flag. The responder looks the address up in a small tag and state table. It reports a plain hit one clock later, and a hit on a dirty line one clock after that.

A dirty hit makes the responder claim the bus as soon as hold is released. It pushes the dirty line out as a four-beat burst write. Any processor transfers queued in the meantime wait until the burst is done. When the last beat completes, the dirty-hit indication is withdrawn and the line drops to shared or invalid according to the invalidate flag. A snoop that hits a clean line changes its state at once and never claims the bus.

The hold acknowledge follows the hold request one clock later. While the acknowledge is high, the responder's bus drivers are disabled. A fill port installs a tag, state and data for a line. The line data doubles as the write-back buffer.

Top module: `wbsnp_responder`

## Requirements
- R1: Line states are coded 0 invalid, 1 shared, 2 exclusive, 3 modified. `hit_n` is low in the first clock after a snoop strobe is sampled low if the snooped tag matches the line selected by the index bits and that line's state is not 0. Otherwise it stays high.
- R2: `mod_hit_n` goes low in the second clock after a snoop strobe that hits a line in state 3. A hit on state 1 or 2 leaves it high.
- R3: A snoop hit on a line in state 1 or 2 sets the line to shared when `snoop_inval` is 0 and to invalid when it is 1, with no bus activity. A snoop that misses leaves every line unchanged.
- R4: A pending write-back starts on the second clock after `hold_req` is sampled low. Its first cycle has `addr_strobe_n` low for exactly one cycle, `cacheable_n` low, `write_nread` high and `bus_addr` at the line base.
- R5: The burst has four data beats. Beat k carries address base+4k and data bits [32k+31:32k] of the line. A beat completes only in a clock where `beat_ready_n` is low. `last_beat_n` is low only during beat 3.
- R6: `mod_hit_n` returns high in the clock after the beat where `last_beat_n` and `beat_ready_n` are both low. The line then reads as shared if the snoop had `snoop_inval` 0, and as invalid if it had 1.
- R7: `hold_ack` rises one clock after `hold_req` is sampled high while the bus is idle, and falls one clock after it is sampled low. While it is high, `bus_drive_en` is low and no transfer starts.
- R8: A write-back that is pending when the bus frees up is issued before any queued processor request.
- R9: Processor requests enter a two-entry queue, and `req_ready` is low while it is full. Queued requests are issued in order as single transfers. Each has a one-cycle strobe, `cacheable_n` high, `write_nread` equal to `req_write`, and then one data cycle with `last_beat_n` low that ends on `beat_ready_n` low.
- R10: A fill pulse installs the tag, state and line data given on the fill port at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| snoop_strobe_n | input | 1 | Snoop request, active low |
| snoop_addr | input | ADDR_W | Snooped address |
| snoop_inval | input | 1 | Invalidate the line after the snoop |
| hit_n | output | 1 | Snoop hit on a valid line, active low |
| mod_hit_n | output | 1 | Snoop hit on a modified line, active low |
| fill_en | input | 1 | Install a line |
| fill_addr | input | ADDR_W | Address of the installed line |
| fill_state | input | 2 | State of the installed line |
| fill_data | input | BEATS*DATA_W | Data of the installed line, beat 0 in the low bits |
| req_valid | input | 1 | Processor request present |
| req_addr | input | ADDR_W | Processor request address |
| req_write | input | 1 | Processor request is a write |
| req_wdata | input | DATA_W | Processor write data |
| req_ready | output | 1 | Request queue can accept |
| hold_req | input | 1 | Another master asks for the bus |
| hold_ack | output | 1 | Bus granted to the other master |
| addr_strobe_n | output | 1 | Address strobe, active low |
| bus_addr | output | ADDR_W | Bus address |
| cacheable_n | output | 1 | Line transfer marker, active low |
| write_nread | output | 1 | High for a write cycle |
| last_beat_n | output | 1 | Final beat of the transfer, active low |
| beat_ready_n | input | 1 | Beat accepted by the target, active low |
| bus_wdata | output | DATA_W | Bus write data |
| bus_drive_en | output | 1 | Enable for the address, control and data drivers |

## Verification
The hardest situation to set up is a dirty snoop hit while processor requests are already queued behind a held bus. It has to be shown that the burst still goes first and that the queue then drains in order. The bench holds the bus and installs a modified line through the fill port. It snoops the line, fills the queue to its limit while the hold is still in force, and only then releases the hold. Every line index, every state and both invalidate settings are swept. Wait states are inserted between beats with a varying pattern, and each line's final state is read back with a second snoop.

// File: rtl/wbsnp_pkg.sv
`timescale 1ns/1ps
// Shared types for the snooping write-back responder.
// Assumes: two-bit line state coding is fixed by the requirements.
package wbsnp_pkg;

    typedef enum logic [1:0] {
        LS_INV = 2'd0,
        LS_SHR = 2'd1,
        LS_EXC = 2'd2,
        LS_MOD = 2'd3
    } line_st_e;

    typedef enum logic [2:0] {
        BS_IDLE   = 3'd0,
        BS_WB_ADR = 3'd1,
        BS_WB_DAT = 3'd2,
        BS_RQ_ADR = 3'd3,
        BS_RQ_DAT = 3'd4
    } bus_st_e;

endpackage

// File: rtl/wbsnp_line_table.sv
`timescale 1ns/1ps
// Direct-mapped tag, state and data table for the responder.
// Provides a combinational lookup for snoops and a read port for the
// write-back buffer. Writes come from the fill port, the snoop state
// update and the write-back state update, applied in that order.
// Assumes: NLINES is a power of two, at least 2.
module wbsnp_line_table
    import wbsnp_pkg::*;
#(
    parameter int LA_W   = 28,
    parameter int NLINES = 4,
    parameter int LINE_W = 128
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [LA_W-1:0]        lk_line,
    output logic                   lk_hit,
    output line_st_e               lk_st,
    input  logic                   fill_en,
    input  logic [LA_W-1:0]        fill_line,
    input  line_st_e               fill_st,
    input  logic [LINE_W-1:0]      fill_data,
    input  logic                   su_en,
    input  logic [$clog2(NLINES)-1:0] su_idx,
    input  line_st_e               su_st,
    input  logic                   wu_en,
    input  logic [$clog2(NLINES)-1:0] wu_idx,
    input  line_st_e               wu_st,
    input  logic [$clog2(NLINES)-1:0] rd_idx,
    output logic [LINE_W-1:0]      rd_data
);
    localparam int IDX_W = $clog2(NLINES);
    localparam int TAG_W = LA_W - IDX_W;

    line_st_e          st_q   [NLINES];
    logic [TAG_W-1:0]  tag_q  [NLINES];
    logic [LINE_W-1:0] data_q [NLINES];

    logic [IDX_W-1:0] lk_idx;
    logic [IDX_W-1:0] fill_idx;

    assign lk_idx   = lk_line[IDX_W-1:0];
    assign fill_idx = fill_line[IDX_W-1:0];

    // Snoop lookup: match on tag with a valid state.
    always_comb begin
        lk_st  = st_q[lk_idx];
        lk_hit = (st_q[lk_idx] != LS_INV) && (tag_q[lk_idx] == lk_line[LA_W-1:IDX_W]);
    end

    assign rd_data = data_q[rd_idx];

    // State array: reset to invalid, then fill, snoop and write-back updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NLINES; i++) st_q[i] <= LS_INV;
        end else begin
            for (int i = 0; i < NLINES; i++) begin
                if (fill_en && fill_idx == IDX_W'(i)) st_q[i] <= fill_st;
                if (su_en && su_idx == IDX_W'(i))     st_q[i] <= su_st;
                if (wu_en && wu_idx == IDX_W'(i))     st_q[i] <= wu_st;
            end
        end
    end

    // Tag and data storage: written only by the fill port.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NLINES; i++) begin
            if (fill_en && fill_idx == IDX_W'(i)) begin
                tag_q[i]  <= fill_line[LA_W-1:IDX_W];
                data_q[i] <= fill_data;
            end
        end
    end

endmodule

// File: rtl/wbsnp_req_fifo.sv
`timescale 1ns/1ps
// In-order queue for processor bus requests waiting behind a snoop
// write-back or a held bus. A push while full is not taken.
// Assumes: DEPTH of at least 2.
module wbsnp_req_fifo #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [ADDR_W-1:0] push_addr,
    input  logic              push_wr,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic              full,
    output logic              empty,
    output logic [ADDR_W-1:0] head_addr,
    output logic              head_wr,
    output logic [DATA_W-1:0] head_data
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [ADDR_W-1:0] addr_q [DEPTH];
    logic              wr_q   [DEPTH];
    logic [DATA_W-1:0] data_q [DEPTH];
    logic [PTR_W-1:0]  rd_ptr_q, wr_ptr_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              do_push, do_pop;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full      = (cnt_q == CNT_W'(DEPTH));
    assign empty     = (cnt_q == '0);
    assign do_push   = push && !full;
    assign do_pop    = pop && !empty;
    assign head_addr = addr_q[rd_ptr_q];
    assign head_wr   = wr_q[rd_ptr_q];
    assign head_data = data_q[rd_ptr_q];

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr_q <= '0;
            wr_ptr_q <= '0;
            cnt_q    <= '0;
        end else begin
            if (do_push) wr_ptr_q <= ptr_next(wr_ptr_q);
            if (do_pop)  rd_ptr_q <= ptr_next(rd_ptr_q);
            if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
            else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
        end
    end

    // Entry storage, written at the tail.
    always_ff @(posedge clk) begin
        if (do_push) begin
            addr_q[wr_ptr_q] <= push_addr;
            wr_q[wr_ptr_q]   <= push_wr;
            data_q[wr_ptr_q] <= push_data;
        end
    end

endmodule

// File: rtl/wbsnp_bus_seq.sv
`timescale 1ns/1ps
// Bus sequencer: grants hold to another master, runs the snoop
// write-back burst, and runs single queued processor transfers.
// A pending write-back always wins over the queue when the bus frees.
// Assumes: the bus is free only with hold_req and hold_ack both low.
module wbsnp_bus_seq
    import wbsnp_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int BEATS  = 4
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             hold_req,
    input  logic                             beat_ready_n,
    input  logic                             wb_pend,
    input  logic [ADDR_W-$clog2(BEATS)-$clog2(DATA_W/8)-1:0] wb_line,
    input  logic [BEATS*DATA_W-1:0]          wb_data,
    input  logic                             q_valid,
    input  logic [ADDR_W-1:0]                q_addr,
    input  logic                             q_wr,
    input  logic [DATA_W-1:0]                q_data,
    output logic                             wb_done,
    output logic                             rq_done,
    output logic                             hold_ack,
    output logic                             addr_strobe_n,
    output logic [ADDR_W-1:0]                bus_addr,
    output logic                             cacheable_n,
    output logic                             write_nread,
    output logic                             last_beat_n,
    output logic [DATA_W-1:0]                bus_wdata,
    output logic                             bus_drive_en
);
    localparam int BYTE_W = $clog2(DATA_W / 8);
    localparam int BEAT_W = $clog2(BEATS);
    localparam logic [BEAT_W-1:0] LAST = BEAT_W'(BEATS - 1);

    bus_st_e           st_q, st_d;
    logic [BEAT_W-1:0] beat_q, beat_d;
    logic              hold_ack_q;
    logic              bus_free;
    logic              in_wb, in_rq;
    logic [DATA_W-1:0] beat_word;

    assign bus_free = !hold_req && !hold_ack_q;
    assign in_wb    = (st_q == BS_WB_ADR) || (st_q == BS_WB_DAT);
    assign in_rq    = (st_q == BS_RQ_ADR) || (st_q == BS_RQ_DAT);

    // Next-state: write-back first, then the queue, only on a free bus.
    always_comb begin
        st_d   = st_q;
        beat_d = beat_q;
        unique case (st_q)
            BS_IDLE: begin
                if (bus_free && wb_pend) begin
                    st_d   = BS_WB_ADR;
                    beat_d = '0;
                end else if (bus_free && q_valid) begin
                    st_d = BS_RQ_ADR;
                end
            end
            BS_WB_ADR: st_d = BS_WB_DAT;
            BS_WB_DAT: begin
                if (!beat_ready_n) begin
                    if (beat_q == LAST) st_d = BS_IDLE;
                    else                beat_d = beat_q + 1'b1;
                end
            end
            BS_RQ_ADR: st_d = BS_RQ_DAT;
            BS_RQ_DAT: if (!beat_ready_n) st_d = BS_IDLE;
            default:   st_d = BS_IDLE;
        endcase
    end

    // Sequencer registers and hold grant (granted only from idle).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= BS_IDLE;
            beat_q     <= '0;
            hold_ack_q <= 1'b0;
        end else begin
            st_q       <= st_d;
            beat_q     <= beat_d;
            hold_ack_q <= hold_req && (st_q == BS_IDLE);
        end
    end

    // Select the current beat's word from the line buffer.
    always_comb begin
        beat_word = '0;
        for (int k = 0; k < BEATS; k++) begin
            if (beat_q == BEAT_W'(k)) beat_word = wb_data[k*DATA_W +: DATA_W];
        end
    end

    assign wb_done       = (st_q == BS_WB_DAT) && !beat_ready_n && (beat_q == LAST);
    assign rq_done       = (st_q == BS_RQ_DAT) && !beat_ready_n;
    assign hold_ack      = hold_ack_q;
    assign bus_drive_en  = !hold_ack_q;
    assign addr_strobe_n = !((st_q == BS_WB_ADR) || (st_q == BS_RQ_ADR));
    assign cacheable_n   = !in_wb;
    assign write_nread   = in_wb || (in_rq && q_wr);
    assign last_beat_n   = !(((st_q == BS_WB_DAT) && (beat_q == LAST)) || (st_q == BS_RQ_DAT));
    assign bus_addr      = in_wb ? {wb_line, beat_q, {BYTE_W{1'b0}}} : q_addr;
    assign bus_wdata     = in_wb ? beat_word : q_data;

endmodule

// File: rtl/wbsnp_responder.sv
`timescale 1ns/1ps
// Snooping write-back responder top. Registers the snoop lookup,
// raises the dirty-hit flag one clock later, holds the write-back
// request until the burst ends, and ties the line table, request
// queue and bus sequencer together.
// Assumes: one write-back in flight; a dirty hit while one is pending
// reports a hit but starts nothing new.
module wbsnp_responder
    import wbsnp_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int BEATS  = 4,
    parameter int NLINES = 4,
    parameter int QDEPTH = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    snoop_strobe_n,
    input  logic [ADDR_W-1:0]       snoop_addr,
    input  logic                    snoop_inval,
    output logic                    hit_n,
    output logic                    mod_hit_n,
    input  logic                    fill_en,
    input  logic [ADDR_W-1:0]       fill_addr,
    input  logic [1:0]              fill_state,
    input  logic [BEATS*DATA_W-1:0] fill_data,
    input  logic                    req_valid,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic                    req_write,
    input  logic [DATA_W-1:0]       req_wdata,
    output logic                    req_ready,
    input  logic                    hold_req,
    output logic                    hold_ack,
    output logic                    addr_strobe_n,
    output logic [ADDR_W-1:0]       bus_addr,
    output logic                    cacheable_n,
    output logic                    write_nread,
    output logic                    last_beat_n,
    input  logic                    beat_ready_n,
    output logic [DATA_W-1:0]       bus_wdata,
    output logic                    bus_drive_en
);
    localparam int BYTE_W = $clog2(DATA_W / 8);
    localparam int BEAT_W = $clog2(BEATS);
    localparam int OFF_W  = BYTE_W + BEAT_W;
    localparam int IDX_W  = $clog2(NLINES);
    localparam int LA_W   = ADDR_W - OFF_W;
    localparam int LINE_W = BEATS * DATA_W;

    logic              lk_hit;
    line_st_e          lk_st;
    logic              s1_hit, s1_inval;
    line_st_e          s1_st;
    logic [LA_W-1:0]   s1_line;
    logic              snp_mod, snp_upd;
    line_st_e          snp_upd_st;
    logic              wb_pend_q, wb_inval_q, mod_hit_n_q;
    logic [LA_W-1:0]   wb_line_q;
    line_st_e          wb_upd_st;
    logic              wb_done, rq_done;
    logic [LINE_W-1:0] wb_data;
    logic              q_full, q_empty;
    logic [ADDR_W-1:0] q_addr;
    logic              q_wr;
    logic [DATA_W-1:0] q_data;
    logic              unused_offset_bits;

    assign unused_offset_bits = ^{snoop_addr[OFF_W-1:0], fill_addr[OFF_W-1:0]};

    wbsnp_line_table #(
        .LA_W   (LA_W),
        .NLINES (NLINES),
        .LINE_W (LINE_W)
    ) table_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_line   (snoop_addr[ADDR_W-1:OFF_W]),
        .lk_hit    (lk_hit),
        .lk_st     (lk_st),
        .fill_en   (fill_en),
        .fill_line (fill_addr[ADDR_W-1:OFF_W]),
        .fill_st   (line_st_e'(fill_state)),
        .fill_data (fill_data),
        .su_en     (snp_upd),
        .su_idx    (s1_line[IDX_W-1:0]),
        .su_st     (snp_upd_st),
        .wu_en     (wb_done),
        .wu_idx    (wb_line_q[IDX_W-1:0]),
        .wu_st     (wb_upd_st),
        .rd_idx    (wb_line_q[IDX_W-1:0]),
        .rd_data   (wb_data)
    );

    // Snoop stage one: capture the lookup result for the next clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_hit   <= 1'b0;
            s1_inval <= 1'b0;
            s1_st    <= LS_INV;
            s1_line  <= '0;
        end else begin
            s1_hit   <= !snoop_strobe_n && lk_hit;
            s1_inval <= snoop_inval;
            s1_st    <= lk_st;
            s1_line  <= snoop_addr[ADDR_W-1:OFF_W];
        end
    end

    assign hit_n      = !s1_hit;
    assign snp_mod    = s1_hit && (s1_st == LS_MOD) && !wb_pend_q;
    assign snp_upd    = s1_hit && (s1_st != LS_MOD);
    assign snp_upd_st = s1_inval ? LS_INV : LS_SHR;
    assign wb_upd_st  = wb_inval_q ? LS_INV : LS_SHR;

    // Snoop stage two: dirty-hit flag and write-back request until the burst ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_pend_q   <= 1'b0;
            wb_inval_q  <= 1'b0;
            mod_hit_n_q <= 1'b1;
            wb_line_q   <= '0;
        end else if (wb_done) begin
            wb_pend_q   <= 1'b0;
            mod_hit_n_q <= 1'b1;
        end else if (snp_mod) begin
            wb_pend_q   <= 1'b1;
            mod_hit_n_q <= 1'b0;
            wb_line_q   <= s1_line;
            wb_inval_q  <= s1_inval;
        end
    end

    assign mod_hit_n = mod_hit_n_q;

    wbsnp_req_fifo #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .DEPTH  (QDEPTH)
    ) queue_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (req_valid),
        .push_addr (req_addr),
        .push_wr   (req_write),
        .push_data (req_wdata),
        .pop       (rq_done),
        .full      (q_full),
        .empty     (q_empty),
        .head_addr (q_addr),
        .head_wr   (q_wr),
        .head_data (q_data)
    );

    assign req_ready = !q_full;

    wbsnp_bus_seq #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .BEATS  (BEATS)
    ) seq_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .hold_req      (hold_req),
        .beat_ready_n  (beat_ready_n),
        .wb_pend       (wb_pend_q),
        .wb_line       (wb_line_q),
        .wb_data       (wb_data),
        .q_valid       (!q_empty),
        .q_addr        (q_addr),
        .q_wr          (q_wr),
        .q_data        (q_data),
        .wb_done       (wb_done),
        .rq_done       (rq_done),
        .hold_ack      (hold_ack),
        .addr_strobe_n (addr_strobe_n),
        .bus_addr      (bus_addr),
        .cacheable_n   (cacheable_n),
        .write_nread   (write_nread),
        .last_beat_n   (last_beat_n),
        .bus_wdata     (bus_wdata),
        .bus_drive_en  (bus_drive_en)
    );

endmodule

// File: rtl/wbsnp_responder_chk.sv
`timescale 1ns/1ps
// Protocol checker for the responder, attached by bind. Observes ports only.
// Assumes: reset is held low for at least one clock at start-up.
module wbsnp_responder_chk #(
    parameter int BEATS = 4
) (
    input logic clk,
    input logic rst_n,
    input logic hit_n,
    input logic mod_hit_n,
    input logic hold_req,
    input logic hold_ack,
    input logic addr_strobe_n,
    input logic cacheable_n,
    input logic write_nread,
    input logic last_beat_n,
    input logic beat_ready_n,
    input logic bus_drive_en
);
    logic [7:0] beats_seen_q;

    // Count accepted line-transfer beats since the last strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)                             beats_seen_q <= '0;
        else if (!addr_strobe_n)                beats_seen_q <= '0;
        else if (!cacheable_n && !beat_ready_n) beats_seen_q <= beats_seen_q + 1'b1;
    end

    // R2
    dirty_flag_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mod_hit_n) |-> $past(!hit_n));

    // R6
    dirty_flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mod_hit_n) |-> $past(!last_beat_n && !beat_ready_n && !cacheable_n));

    // R7
    hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_ack |-> (addr_strobe_n && !bus_drive_en));

    // R7
    hold_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_ack) |-> $past(hold_req));

    // R4
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_strobe_n |=> addr_strobe_n);

    // R4
    wb_is_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!addr_strobe_n && !cacheable_n) |-> (write_nread && !mod_hit_n));

    // R5
    last_beat_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cacheable_n && addr_strobe_n && !last_beat_n) |-> (beats_seen_q == 8'(BEATS - 1)));

endmodule

bind wbsnp_responder wbsnp_responder_chk #(.BEATS(BEATS)) chk_i (.*);

// File: tb/wbsnp_responder_tb_top.sv
`timescale 1ns/1ps
// Sweep bench: every line index, state and invalidate setting.
module wbsnp_responder_tb_top;
    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int BEATS  = 4;
    localparam int LINE_W = BEATS * DATA_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              snoop_strobe_n = 1'b1;
    logic [ADDR_W-1:0] snoop_addr = '0;
    logic              snoop_inval = 1'b0;
    logic              hit_n, mod_hit_n;
    logic              fill_en = 1'b0;
    logic [ADDR_W-1:0] fill_addr = '0;
    logic [1:0]        fill_state = '0;
    logic [LINE_W-1:0] fill_data = '0;
    logic              req_valid = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              req_write = 1'b0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic              req_ready;
    logic              hold_req = 1'b0;
    logic              hold_ack;
    logic              addr_strobe_n;
    logic [ADDR_W-1:0] bus_addr;
    logic              cacheable_n, write_nread, last_beat_n;
    logic              beat_ready_n = 1'b1;
    logic [DATA_W-1:0] bus_wdata;
    logic              bus_drive_en;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    wbsnp_responder dut_i (
        .clk(clk), .rst_n(rst_n),
        .snoop_strobe_n(snoop_strobe_n), .snoop_addr(snoop_addr), .snoop_inval(snoop_inval),
        .hit_n(hit_n), .mod_hit_n(mod_hit_n),
        .fill_en(fill_en), .fill_addr(fill_addr), .fill_state(fill_state), .fill_data(fill_data),
        .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write), .req_wdata(req_wdata),
        .req_ready(req_ready),
        .hold_req(hold_req), .hold_ack(hold_ack),
        .addr_strobe_n(addr_strobe_n), .bus_addr(bus_addr), .cacheable_n(cacheable_n),
        .write_nread(write_nread), .last_beat_n(last_beat_n), .beat_ready_n(beat_ready_n),
        .bus_wdata(bus_wdata), .bus_drive_en(bus_drive_en)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", r, act, exp);
        end
    endtask

    function automatic logic [31:0] pat(input int c, input int b);
        return 32'h5A00_0000 + 32'(c * 256 + b * 17 + 1);
    endfunction

    // Snoop once; hit is checked one clock later, dirty flag two clocks later.
    task automatic do_snoop(input logic [31:0] a, input logic inv, input logic eh, input logic em, input string r);
        snoop_addr = a; snoop_inval = inv; snoop_strobe_n = 1'b0;
        step();
        snoop_strobe_n = 1'b1;
        chk({r, " R1 hit"}, 32'(hit_n), 32'(!eh));
        step();
        chk({r, " R2 dirty flag"}, 32'(mod_hit_n), 32'(!em));
    endtask

    // One queued transfer, starting from idle with the bus free.
    task automatic do_req(input logic [31:0] a, input logic wr, input logic [31:0] d);
        step();
        chk("R9 req strobe", 32'(addr_strobe_n), 0);
        chk("R9 req addr", bus_addr, a);
        chk("R9 req cacheable_n", 32'(cacheable_n), 1);
        chk("R9 req dir", 32'(write_nread), 32'(wr));
        step();
        chk("R9 req last", 32'(last_beat_n), 0);
        if (wr) chk("R9 req data", bus_wdata, d);
        beat_ready_n = 1'b0;
        step();
        beat_ready_n = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (4) step();
        rst_n = 1'b1;
        step();
        chk("R1 reset hit_n", 32'(hit_n), 1);
        chk("R2 reset mod_hit_n", 32'(mod_hit_n), 1);
        chk("R7 reset hold_ack", 32'(hold_ack), 0);
        chk("R7 reset drive_en", 32'(bus_drive_en), 1);
        chk("R4 reset strobe", 32'(addr_strobe_n), 1);
        chk("R9 reset ready", 32'(req_ready), 1);

        for (int c = 0; c < 32; c++) begin
            int idx, st, waits;
            logic inv, after_hit;
            logic [31:0] base, q0a, q1a, q0d;
            idx  = c % 4;
            st   = (c / 4) % 4;
            inv  = (c >= 16);
            base = {26'(c * 7 + 3), 2'(idx), 4'h0};
            q0a  = 32'h8000_0100 + 32'(c * 8);
            q1a  = 32'h9000_0200 + 32'(c * 8);
            q0d  = 32'hC0DE_0000 + 32'(c);

            // R10: install the line
            fill_en = 1'b1; fill_addr = base; fill_state = 2'(st);
            for (int b = 0; b < BEATS; b++) fill_data[b*DATA_W +: DATA_W] = pat(c, b);
            step();
            fill_en = 1'b0;

            // R7: hold grant one clock later
            hold_req = 1'b1;
            chk("R7 ack before", 32'(hold_ack), 0);
            step();
            chk("R7 ack", 32'(hold_ack), 1);
            chk("R7 drive_en", 32'(bus_drive_en), 0);

            // R1/R3: a tag miss changes nothing
            do_snoop(base ^ 32'h8000_0000, 1'b1, 1'b0, 1'b0, "R3 miss");
            // R10: the installed line is visible to the snoop
            do_snoop(base, inv, st != 0, st == 3, "R10 main");

            if (st == 3) begin
                // R9: fill the queue while the bus is held
                req_valid = 1'b1; req_addr = q0a; req_write = 1'b1; req_wdata = q0d;
                chk("R9 ready empty", 32'(req_ready), 1);
                step();
                req_addr = q1a; req_write = 1'b0;
                step();
                req_valid = 1'b0;
                chk("R9 ready full", 32'(req_ready), 0);
                chk("R7 no strobe in hold", 32'(addr_strobe_n), 1);

                // R4/R8: release, burst comes first
                hold_req = 1'b0;
                step();
                chk("R7 ack falls", 32'(hold_ack), 0);
                chk("R4 no early strobe", 32'(addr_strobe_n), 1);
                step();
                chk("R4 wb strobe", 32'(addr_strobe_n), 0);
                chk("R8 wb first cacheable_n", 32'(cacheable_n), 0);
                chk("R4 wb write", 32'(write_nread), 1);
                chk("R4 wb base", bus_addr, base);
                chk("R5 not last", 32'(last_beat_n), 1);
                step();
                for (int b = 0; b < BEATS; b++) begin
                    waits = (b + c) % 3;
                    for (int w = 0; w < waits; w++) begin
                        chk("R5 held addr", bus_addr, base + 32'(4 * b));
                        step();
                    end
                    chk("R5 beat addr", bus_addr, base + 32'(4 * b));
                    chk("R5 beat data", bus_wdata, pat(c, b));
                    chk("R5 last flag", 32'(last_beat_n), (b == BEATS - 1) ? 0 : 1);
                    chk("R6 flag held", 32'(mod_hit_n), 0);
                    beat_ready_n = 1'b0;
                    step();
                    beat_ready_n = 1'b1;
                end
                chk("R6 flag released", 32'(mod_hit_n), 1);
                chk("R6 bus idle after", 32'(addr_strobe_n), 1);

                // R9: queue drains in order
                do_req(q0a, 1'b1, q0d);
                do_req(q1a, 1'b0, 32'h0);
                chk("R9 ready drained", 32'(req_ready), 1);

                // R6: final state by re-snoop
                do_snoop(base, 1'b0, !inv, 1'b0, "R6 after");
            end else begin
                // R3: clean line state change
                after_hit = (st != 0) && !inv;
                do_snoop(base, 1'b0, after_hit, 1'b0, "R3 after");
                hold_req = 1'b0;
                step(); step(); step();
                chk("R3 no bus activity", 32'(addr_strobe_n), 1);
                chk("R3 dirty flag idle", 32'(mod_hit_n), 1);
            end
            step();
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule